// File: doc/BRIEF.md
# Serial Grayscale Data Loader

This block is the serial front end of a 16-channel, 12-bit intensity controller. Bits arrive one at a time on a valid/ready stream and are pushed into a 192-bit shift chain. A latch strobe copies the whole chain into a parallel holding register, whose contents drive the PWM engine downstream. On the same strobe the chain is preloaded with a status word. The next input frame therefore pushes that status out of the serial output while new intensity data is pushed in. Several devices can be chained by feeding each one's serial output into the next one's serial input.

The serial output always shows the most significant bit of the chain. A bit shifted into the chain reaches the output 192 accepted shifts later. Channel k sits in bits `[12k+11:12k]` of the parallel output. The first bit of a frame goes to the MSB of channel 15, and each channel word is sent MSB first.

The stream has these rules. A bit transfers on a clock edge where `sin_valid` and `sin_ready` are both high. `sin_ready` drops only in a cycle where a latch is applied in load mode. A bit offered in that cycle is not taken, and the sender must hold it or offer it again. The sender may drop `sin_valid` at any time.

When `mode_sel` is high the block is outside grayscale-load mode. Offered bits are taken but discarded, and latch strobes do nothing.

Top module: `gsl_loader`

## Requirements
- R1: While reset is asserted, and right after it is released, `gs_data` is all zeros, `sout` is 0 and `frame_err` is 0.
- R2: When `mode_sel` is low and no latch is applied, each accepted bit enters the least significant end of the chain. `sout` shows the chain MSB, so it shows the bit accepted 192 shifts earlier, one cycle after the edge that moved it there.
- R3: After exactly 192 accepted bits and a latch, the first bit sent is in `gs_data[191]`, the MSB of channel 15. Channel k holds bits `[12k+11:12k]`, and each channel word arrives MSB first, starting with channel 15.
- R4: A latch with `mode_sel` low copies the chain into `gs_data`, which is visible in the cycle after the edge. At any other time `gs_data` holds its value.
- R5: On a latch with `mode_sel` low, the chain is loaded with `status_in` in its top STW bits and zeros below them. `sout` then shows the status bits MSB first over the next STW shifts, followed by the zero bits.
- R6: `sin_ready` is low exactly when `latch` is high and `mode_sel` is low. A bit offered in that cycle is not shifted.
- R7: While `mode_sel` is high, offered bits and latch strobes change neither `gs_data`, nor `sout`, nor `frame_err`.
- R8: A latch applied when the number of bits accepted since the previous latch (or since reset) is not a multiple of 192 still transfers the chain. It also sets `frame_err`, which stays set until reset.
- R9: A latch applied after a whole number of 192-bit frames leaves `frame_err` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Low selects grayscale-load mode |
| sin_valid | input | 1 | Serial bit on `sin_data` is offered |
| sin_data | input | 1 | Serial input bit |
| sin_ready | output | 1 | Block can accept the offered bit |
| latch | input | 1 | Transfer strobe, one cycle per latch |
| status_in | input | STW (24) | Status word preloaded into the chain on a latch |
| sout | output | 1 | Chain MSB, the daisy-chain output |
| gs_data | output | NCH*GSW (192) | Parallel grayscale register, channel k at `[12k+11:12k]` |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume the following about the inputs. `status_in` is stable in a latch cycle. `latch` and `mode_sel` are clean synchronous levels. The reset is held low for at least one clock edge. The stimulus changes every input only on the falling clock edge, so each input is steady at the sampling edge. The stimulus keeps `status_in` constant for the whole run. It applies latches both with `sin_valid` high and with it low. It enters and leaves the non-load mode only between frames, so the framing count it relies on stays easy to predict.

// File: rtl/gsl_pkg.sv
package gsl_pkg;
  parameter int GSL_NCH = 16;
  parameter int GSL_GSW = 12;
  parameter int GSL_STW = 24;

  function automatic int gsl_cnt_width(input int total);
    return (total > 1) ? $clog2(total) : 1;
  endfunction
endpackage

// File: rtl/gsl_shift_chain.sv
module gsl_shift_chain #(
  parameter int TOT = 192,
  parameter int STW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           sin,
  input  logic           load_en,
  input  logic [STW-1:0] status,
  output logic [TOT-1:0] chain,
  output logic           sout
);
  localparam int PADW = TOT - STW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (load_en) begin
      chain <= {status, {PADW{1'b0}}};
    end else if (shift_en) begin
      chain <= {chain[TOT-2:0], sin};
    end
  end

  assign sout = chain[TOT-1];

  assert_status_preload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (chain[TOT-1 -: STW] == $past(status)) && (sout == $past(status[STW-1])));
endmodule

// File: rtl/gsl_frame_counter.sv
module gsl_frame_counter #(
  parameter int TOT = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic load_en,
  output logic frame_err
);
  localparam int CW = gsl_pkg::gsl_cnt_width(TOT);
  localparam logic [CW-1:0] LAST = CW'(TOT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      frame_err <= 1'b0;
    end else if (load_en) begin
      cnt <= '0;
      if (cnt != '0) frame_err <= 1'b1;
    end else if (shift_en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
endmodule

// File: rtl/gsl_hold_reg.sv
module gsl_hold_reg #(
  parameter int TOT = 192
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [TOT-1:0] d,
  output logic [TOT-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load_en) q <= d;
  end

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));
endmodule

// File: rtl/gsl_loader.sv
module gsl_loader #(
  parameter int NCH = gsl_pkg::GSL_NCH,
  parameter int GSW = gsl_pkg::GSL_GSW,
  parameter int STW = gsl_pkg::GSL_STW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_sel,
  input  logic               sin_valid,
  input  logic               sin_data,
  output logic               sin_ready,
  input  logic               latch,
  input  logic [STW-1:0]     status_in,
  output logic               sout,
  output logic [NCH*GSW-1:0] gs_data,
  output logic               frame_err
);
  localparam int TOT = NCH * GSW;

  logic           load_go;
  logic           shift_go;
  logic [TOT-1:0] chain;

  assign load_go   = latch & ~mode_sel;
  assign sin_ready = ~load_go;
  assign shift_go  = sin_valid & sin_ready & ~mode_sel;

  gsl_shift_chain #(.TOT(TOT), .STW(STW)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_go), .sin(sin_data),
    .load_en(load_go), .status(status_in), .chain(chain), .sout(sout)
  );

  gsl_frame_counter #(.TOT(TOT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_go), .load_en(load_go),
    .frame_err(frame_err)
  );

  gsl_hold_reg #(.TOT(TOT)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_en(load_go), .d(chain), .q(gs_data)
  );

  assert_mode_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |=> $stable(gs_data) && $stable(sout) && $stable(frame_err));
endmodule

// File: tb/sim_gsl_loader.sv
`timescale 1ns/1ps
module sim_gsl_loader;
  localparam int NCH = 16, GSW = 12, STW = 24, TOT = NCH * GSW;
  localparam logic [STW-1:0] STAT = 24'hC35A96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_sel = 1'b0, sin_valid = 1'b0, sin_data = 1'b0, latch = 1'b0;
  logic [STW-1:0] status_in = STAT;
  logic sin_ready, sout, frame_err;
  logic [TOT-1:0] gs_data;

  int n_cmp = 0, n_bad = 0;
  bit mq[$];
  logic [TOT-1:0] mgs = '0;
  bit merr = 1'b0;
  int mcnt = 0;

  always #2.5 clk = ~clk;

  gsl_loader #(.NCH(NCH), .GSW(GSW), .STW(STW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sin_valid(sin_valid),
    .sin_data(sin_data), .sin_ready(sin_ready), .latch(latch),
    .status_in(status_in), .sout(sout), .gs_data(gs_data), .frame_err(frame_err)
  );

  task automatic check(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [GSW-1:0] chan_val(input int seed, input int ch);
    return GSW'((ch * 37 * seed + seed * 111 + ch) & 12'hFFF);
  endfunction

  function automatic bit frame_bit(input int seed, input int idx);
    int ch = NCH - 1 - idx / GSW;
    int bp = GSW - 1 - idx % GSW;
    logic [GSW-1:0] v = chan_val(seed, ch);
    return v[bp];
  endfunction

  task automatic step(input bit m, input bit v, input bit d, input bit l);
    mode_sel = m; sin_valid = v; sin_data = d; latch = l;
    #1;
    check("R6 sin_ready", TOT'(sin_ready), TOT'(!(l && !m)));
    @(posedge clk);
    if (!m) begin
      if (l) begin
        for (int i = 0; i < TOT; i++) mgs[TOT-1-i] = mq[i];
        if (mcnt % TOT != 0) merr = 1'b1;
        mcnt = 0;
        mq = {};
        for (int i = 0; i < STW; i++) mq.push_back(STAT[STW-1-i]);
        for (int i = STW; i < TOT; i++) mq.push_back(1'b0);
      end else if (v) begin
        void'(mq.pop_front());
        mq.push_back(d);
        mcnt++;
      end
    end
    @(negedge clk);
    check("R2/R5 sout", TOT'(sout), TOT'(mq[0]));
    check("R4 gs_data", gs_data, mgs);
    check("R8 frame_err", TOT'(frame_err), TOT'(merr));
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [TOT-1:0] sv_gs;
    bit sv_out;
    for (int i = 0; i < TOT; i++) mq.push_back(1'b0);
    repeat (3) @(negedge clk);
    check("R1 gs_data in reset", gs_data, '0);
    check("R1 sout in reset", TOT'(sout), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {gs_data[TOT-1:2], sout, frame_err}, '0);

    // frame 1 with gaps in valid
    for (int i = 0; i < TOT; i++) begin
      if (i % 17 == 5) step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, frame_bit(3, i), 1'b0);
    end
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int ch = 0; ch < NCH; ch++)
      check($sformatf("R3 channel %0d", ch), TOT'(gs_data[ch*GSW +: GSW]), TOT'(chan_val(3, ch)));
    check("R9 err clear on whole frame", TOT'(frame_err), '0);

    // frame 2: status shifts out first
    for (int i = 0; i < TOT; i++) begin
      if (i < STW) check($sformatf("R5 status bit %0d", i), TOT'(sout), TOT'(STAT[STW-1-i]));
      step(1'b0, 1'b1, frame_bit(7, i), 1'b0);
    end
    // latch with valid high: offered bit dropped
    step(1'b0, 1'b1, 1'b1, 1'b1);
    for (int ch = 0; ch < NCH; ch++)
      check($sformatf("R3 frame2 channel %0d", ch), TOT'(gs_data[ch*GSW +: GSW]), TOT'(chan_val(7, ch)));
    check("R6/R9 err after latch with valid", TOT'(frame_err), '0);

    // non-load mode
    sv_gs = gs_data; sv_out = sout;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, i[0], i % 5 == 0);
    check("R7 gs_data unchanged", gs_data, sv_gs);
    check("R7 sout unchanged", TOT'(sout), TOT'(sv_out));
    check("R7 err unchanged", TOT'(frame_err), '0);

    // short frame then whole frame
    for (int i = 0; i < 100; i++) step(1'b0, 1'b1, frame_bit(9, i), 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 err set on short frame", TOT'(frame_err), TOT'(1'b1));
    for (int i = 0; i < TOT; i++) step(1'b0, 1'b1, frame_bit(11, i), 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 err sticky", TOT'(frame_err), TOT'(1'b1));
    check("R8 latch still transfers", TOT'(gs_data[NCH*GSW-1 -: GSW]), TOT'(chan_val(11, NCH-1)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule